// File: doc/BRIEF.md
# Lite UART register block

This block is the register front end of a small UART. A processor reaches four word registers through a simple strobe bus: receive data, transmit data, status and control. Bytes from the serial receiver come in on a valid/ready stream and collect in an eight-entry circular receive FIFO. Bytes written by software go into a sixteen-entry transmit FIFO, which empties onto a valid/ready output stream for the serial transmitter.

A sticky pending flag records that the block needs attention. Receive data sets it, and so does any write to the transmit register. The single level interrupt output is that flag gated by an enable bit in control. Control writes can also flush either FIFO. A strap input chooses little- or big-endian byte-lane placement for byte-wide accesses.

Top module: `lite_uart_regs`

## Requirements
- R1: Register index is bus_addr[3:2]: 0 receive data, 1 transmit data, 2 status, 3 control. After reset, status reads 0x04, control reads 0, irq is low, rx_ready is high and tx_valid is low.
- R2: Status bit positions: bit0 receive data available, bit1 receive FIFO full, bit2 transmit FIFO empty, bit3 transmit FIFO full, bit4 pending, bit5 overrun. Bits 6 and 7 read as 0.
- R3: The receive FIFO holds 8 bytes. Each read of register 0 returns the oldest byte and removes it, so bytes come out in arrival order.
- R4: A read of register 0 while the receive FIFO is empty returns the byte stored at the current write slot. It does not change the FIFO contents, the count or the write position.
- R5: While the receive FIFO holds 8 bytes, rx_ready is low. A byte offered in that state is dropped and sets the overrun bit.
- R6: A control write stores the written value. If bit1 of the value is 1, the receive FIFO is emptied and its write slot goes back to 0. If bit0 is 1, the transmit FIFO is emptied.
- R7: Writes to the status register change no register.
- R8: The pending bit is set whenever the receive FIFO is non-empty and on every transmit-register write. A status read returns the bits as they were before the read. The read then clears overrun, and it clears pending only if the receive FIFO is empty.
- R9: irq equals pending AND control bit4.
- R10: Each transmit-register write queues byte [7:0] in a 16-entry FIFO. The FIFO drains in order on tx_valid && tx_ready. A write while the FIFO holds 16 bytes is discarded.
- R11: When bus_byte is 1, the access uses one byte lane. That lane is bus_addr[1:0] when big_endian is 0 and 3-bus_addr[1:0] when big_endian is 1. A write takes the register value from that lane, zero-extended. A read returns the register's low byte in that lane and zero in the other lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| big_endian | input | 1 | Byte-lane order strap for byte accesses |
| bus_addr | input | 4 | Byte address; [3:2] picks the register |
| bus_byte | input | 1 | 1 for a byte access, 0 for a word access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access; ignored while bus_wr is high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of bus_rd |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | Received byte offered |
| rx_ready | output | 1 | Receive FIFO can take a byte |
| tx_data | output | 8 | Byte to transmit |
| tx_valid | output | 1 | Transmit FIFO non-empty |
| tx_ready | input | 1 | Transmitter takes the byte |
| irq | output | 1 | Level interrupt |

## Verification
The hardest state to reach is an empty receive FIFO whose write slot sits mid-ring, with older bytes still in memory. Only in that state does a stale read return a recognisable value that proves nothing moved. The bench reaches it in steps. It first offsets the write slot with three bytes. It then fills the FIFO with eight more plus one byte that is dropped, and drains all eight. The empty read should then return the first of those eight, and a fresh byte pushed afterwards must read back unchanged.

// File: rtl/lu_pkg.sv
// Package: register indices and bit positions shared by the lite UART block.
// Assumes register index comes from byte address bits [3:2].
package lu_pkg;
    typedef enum logic [1:0] {
        REG_RXD  = 2'd0,
        REG_TXD  = 2'd1,
        REG_STAT = 2'd2,
        REG_CTRL = 2'd3
    } lu_reg_e;

    localparam int ST_RXAVAIL = 0;
    localparam int ST_RXFULL  = 1;
    localparam int ST_TXEMPTY = 2;
    localparam int ST_TXFULL  = 3;
    localparam int ST_PEND    = 4;
    localparam int ST_OVR     = 5;

    localparam int CT_TXFLUSH = 0;
    localparam int CT_RXFLUSH = 1;
    localparam int CT_IRQEN   = 4;
endpackage

// File: rtl/lu_rx_fifo.sv
// Receive FIFO: circular buffer tracked by a write slot and an occupancy count.
// The read slot is derived as write slot minus count. Assumes DEPTH is a power of two.
// Pop on empty is ignored. Flush wins over push and pop.
module lu_rx_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    input  logic          flush,
    output logic [W-1:0]  head,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] cnt_nxt
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wslot;
    logic [AW-1:0] rslot;
    logic          pop_ok;

    // Oldest entry sits count places behind the write slot.
    always_comb rslot = wslot - cnt[AW-1:0];
    assign head   = mem[rslot];
    assign pop_ok = pop && (cnt != '0);

    // Next occupancy, also used for the pending flag.
    always_comb begin
        if (flush) cnt_nxt = '0;
        else       cnt_nxt = cnt + CW'(push) - CW'(pop_ok);
    end

    // Write slot, count and storage update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wslot <= '0;
            cnt   <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            cnt <= cnt_nxt;
            if (flush) begin
                wslot <= '0;
            end else if (push) begin
                mem[wslot] <= push_data;
                wslot      <= wslot + 1'b1;
            end
        end
    end
endmodule

// File: rtl/lu_tx_fifo.sv
// Transmit FIFO: read and write pointers plus a count. Caller gates push on not full.
// Assumes DEPTH is a power of two. Flush wins over push and pop.
module lu_tx_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    input  logic          flush,
    output logic [W-1:0]  head,
    output logic [CW-1:0] cnt
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp;
    logic [AW-1:0] rp;

    assign head = mem[rp];

    // Pointer, count and storage update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) begin
                mem[wp] <= push_data;
                wp      <= wp + 1'b1;
            end
            if (pop) rp <= rp + 1'b1;
            cnt <= cnt + CW'(push) - CW'(pop);
        end
    end
endmodule

// File: rtl/lu_lane.sv
// Byte-lane steering for byte-wide accesses; word accesses pass straight through.
// Assumes a 32-bit bus and the lane already resolved for endianness.
module lu_lane (
    input  logic        byte_acc,
    input  logic [1:0]  lane,
    input  logic [31:0] wdata,
    input  logic [31:0] rval,
    output logic [31:0] wval,
    output logic [31:0] rdata
);
    logic [4:0] sh;
    assign sh = {lane, 3'b000};

    // Pick the write byte from its lane, or place the read byte into its lane.
    always_comb begin
        if (byte_acc) begin
            wval  = {24'b0, wdata[sh +: 8]};
            rdata = {24'b0, rval[7:0]} << sh;
        end else begin
            wval  = wdata;
            rdata = rval;
        end
    end
endmodule

// File: rtl/lite_uart_regs.sv
// Lite UART register block: four word registers on a single-cycle strobe bus,
// an 8-entry receive FIFO fed by a stream, a 16-entry transmit FIFO drained to a stream,
// and a level interrupt. Assumes bus_rd and bus_wr are one-cycle strobes; write wins.
module lite_uart_regs
    import lu_pkg::*;
#(
    parameter int RX_DEPTH = 8,
    parameter int TX_DEPTH = 16,
    localparam int RX_CW   = $clog2(RX_DEPTH + 1),
    localparam int TX_CW   = $clog2(TX_DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        big_endian,
    input  logic [3:0]  bus_addr,
    input  logic        bus_byte,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic [7:0]  rx_data,
    input  logic        rx_valid,
    output logic        rx_ready,
    output logic [7:0]  tx_data,
    output logic        tx_valid,
    input  logic        tx_ready,
    output logic        irq
);
    lu_reg_e            sel;
    logic [1:0]         lane;
    logic [31:0]        wval, rval;
    logic               rd_s;
    logic [31:0]        ctrl_q, txd_q;
    logic               pend_q, ovr_q;
    logic [7:0]         stat;
    logic [7:0]         rx_head;
    logic [RX_CW-1:0]   rx_cnt, rx_cnt_nxt;
    logic [TX_CW-1:0]   tx_cnt;
    logic               rx_full, tx_full;
    logic               rx_flush, tx_flush, rx_pop, tx_push, tx_pop, tx_wr, st_rd, drop;

    assign sel  = lu_reg_e'(bus_addr[3:2]);
    assign lane = big_endian ? ~bus_addr[1:0] : bus_addr[1:0];
    assign rd_s = bus_rd && !bus_wr;

    lu_lane u_lane (
        .byte_acc (bus_byte),
        .lane     (lane),
        .wdata    (bus_wdata),
        .rval     (rval),
        .wval     (wval),
        .rdata    (bus_rdata)
    );

    // Access decode into FIFO and flag strobes.
    always_comb begin
        rx_flush = bus_wr && (sel == REG_CTRL) && wval[CT_RXFLUSH];
        tx_flush = bus_wr && (sel == REG_CTRL) && wval[CT_TXFLUSH];
        tx_wr    = bus_wr && (sel == REG_TXD);
        tx_push  = tx_wr && !tx_full;
        rx_pop   = rd_s && (sel == REG_RXD);
        st_rd    = rd_s && (sel == REG_STAT);
    end

    assign rx_full  = (rx_cnt == RX_CW'(RX_DEPTH));
    assign tx_full  = (tx_cnt == TX_CW'(TX_DEPTH));
    assign rx_ready = !rx_full && !rx_flush;
    assign drop     = rx_valid && !rx_ready && !rx_flush;
    assign tx_valid = (tx_cnt != '0);
    assign tx_pop   = tx_valid && tx_ready;

    lu_rx_fifo #(.DEPTH(RX_DEPTH), .W(8)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rx_valid && rx_ready),
        .push_data (rx_data),
        .pop       (rx_pop),
        .flush     (rx_flush),
        .head      (rx_head),
        .cnt       (rx_cnt),
        .cnt_nxt   (rx_cnt_nxt)
    );

    lu_tx_fifo #(.DEPTH(TX_DEPTH), .W(8)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (tx_push),
        .push_data (wval[7:0]),
        .pop       (tx_pop),
        .flush     (tx_flush),
        .head      (tx_data),
        .cnt       (tx_cnt)
    );

    // Control, last transmit value and the sticky flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            txd_q  <= '0;
            pend_q <= 1'b0;
            ovr_q  <= 1'b0;
        end else begin
            if (bus_wr && sel == REG_CTRL) ctrl_q <= wval;
            if (tx_wr)                     txd_q  <= wval;
            pend_q <= (pend_q && !st_rd) || tx_wr || (rx_cnt_nxt != '0);
            ovr_q  <= (ovr_q && !st_rd) || drop;
        end
    end

    // Status byte assembled from live FIFO levels and flags.
    always_comb begin
        stat             = '0;
        stat[ST_RXAVAIL] = (rx_cnt != '0);
        stat[ST_RXFULL]  = rx_full;
        stat[ST_TXEMPTY] = (tx_cnt == '0);
        stat[ST_TXFULL]  = tx_full;
        stat[ST_PEND]    = pend_q;
        stat[ST_OVR]     = ovr_q;
    end

    // Register read mux.
    always_comb begin
        unique case (sel)
            REG_RXD:  rval = {24'b0, rx_head};
            REG_TXD:  rval = txd_q;
            REG_STAT: rval = {24'b0, stat};
            default:  rval = ctrl_q;
        endcase
    end

    assign irq = pend_q && ctrl_q[CT_IRQEN];
endmodule

// File: rtl/lite_uart_regs_chk.sv
// Checker for lite_uart_regs: temporal properties on FIFO levels and flags.
// Bound to every instance of the top module.
module lite_uart_regs_chk #(
    parameter int RX_DEPTH = 8,
    parameter int TX_DEPTH = 16,
    localparam int RX_CW   = $clog2(RX_DEPTH + 1),
    localparam int TX_CW   = $clog2(TX_DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       sel,
    input logic             rd,
    input logic             wr,
    input logic [31:0]      wval,
    input logic             rx_valid,
    input logic             rx_ready,
    input logic [RX_CW-1:0] rx_cnt,
    input logic             ovr,
    input logic             pend,
    input logic [TX_CW-1:0] tx_cnt,
    input logic             tx_pop
);
    p_full_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_cnt == RX_CW'(RX_DEPTH)) |-> !rx_ready);

    p_drop_sets_ovr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_cnt == RX_CW'(RX_DEPTH) && !wr) |=> ovr);

    p_empty_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !wr && sel == 2'd0 && rx_cnt == '0 && !(rx_valid && rx_ready)) |=> (rx_cnt == '0));

    p_rx_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel == 2'd3 && wval[1]) |=> (rx_cnt == '0));

    p_tx_sets_pend_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel == 2'd1) |=> pend);

    p_tx_full_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel == 2'd1 && tx_cnt == TX_CW'(TX_DEPTH) && !tx_pop) |=> (tx_cnt == TX_CW'(TX_DEPTH)));
endmodule

bind lite_uart_regs lite_uart_regs_chk #(.RX_DEPTH(RX_DEPTH), .TX_DEPTH(TX_DEPTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (bus_addr[3:2]),
    .rd       (bus_rd),
    .wr       (bus_wr),
    .wval     (wval),
    .rx_valid (rx_valid),
    .rx_ready (rx_ready),
    .rx_cnt   (rx_cnt),
    .ovr      (ovr_q),
    .pend     (pend_q),
    .tx_cnt   (tx_cnt),
    .tx_pop   (tx_pop)
);

// File: tb/test_lite_uart_regs.sv
`timescale 1ns/1ps
// Directed bench for lite_uart_regs; each task drives one scenario and checks it.
module test_lite_uart_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        big_endian = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_byte = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  rx_data = '0;
    logic        rx_valid = 1'b0;
    logic        rx_ready;
    logic [7:0]  tx_data;
    logic        tx_valid;
    logic        tx_ready = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    lite_uart_regs i_lite_uart_regs (
        .clk(clk), .rst_n(rst_n), .big_endian(big_endian),
        .bus_addr(bus_addr), .bus_byte(bus_byte), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, input logic b, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_byte = b; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_rd = 1'b0; bus_byte = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic b, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_byte = b; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0; bus_byte = 1'b0;
    endtask

    task automatic push(input logic [7:0] d, output logic acc);
        @(negedge clk);
        rx_data = d; rx_valid = 1'b1;
        #1 acc = rx_ready;
        @(posedge clk); #1;
        rx_valid = 1'b0;
    endtask

    task automatic clear_pend();
        logic [31:0] d;
        rd(4'h8, 1'b0, d);
        rd(4'h8, 1'b0, d);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 irq after reset", 32'(irq), 32'd0);
        check("R1 rx_ready after reset", 32'(rx_ready), 32'd1);
        check("R1 tx_valid after reset", 32'(tx_valid), 32'd0);
        rd(4'h8, 1'b0, d); check("R1 R2 status after reset", d, 32'h04);
        rd(4'hC, 1'b0, d); check("R1 control after reset", d, 32'h00);
    endtask

    task automatic t_rx_order();
        logic [31:0] d;
        logic a;
        for (int i = 0; i < 3; i++) push(8'hA0 + 8'(i), a);
        rd(4'h8, 1'b0, d); check("R2 R8 status with rx data", d, 32'h15);
        for (int i = 0; i < 3; i++) begin
            rd(4'h0, 1'b0, d); check("R3 rx order", d, 32'hA0 + 32'(i));
        end
        rd(4'h8, 1'b0, d); check("R8 pending sticky after drain", d, 32'h14);
        rd(4'h8, 1'b0, d); check("R8 pending cleared by status read", d, 32'h04);
    endtask

    task automatic t_rx_full();
        logic [31:0] d;
        logic a;
        for (int i = 0; i < 8; i++) begin
            push(8'hB0 + 8'(i), a); check("R5 accept below full", 32'(a), 32'd1);
        end
        push(8'hB8, a); check("R5 rx_ready low when full", 32'(a), 32'd0);
        rd(4'h8, 1'b0, d); check("R2 R5 status full with overrun", d, 32'h37);
        rd(4'h8, 1'b0, d); check("R8 overrun cleared, pending kept", d, 32'h17);
        for (int i = 0; i < 8; i++) begin
            rd(4'h0, 1'b0, d); check("R3 R5 order after drop", d, 32'hB0 + 32'(i));
        end
        rd(4'h0, 1'b0, d); check("R4 empty read returns stale slot", d, 32'hB0);
        rd(4'h8, 1'b0, d); check("R4 status after empty read", d, 32'h14);
        push(8'hC0, a);
        rd(4'h0, 1'b0, d); check("R4 fifo intact after empty read", d, 32'hC0);
        clear_pend();
    endtask

    task automatic t_flush();
        logic [31:0] d;
        logic a;
        push(8'hD0, a); push(8'hD1, a);
        wr(4'hC, 1'b0, 32'h02);
        rd(4'h8, 1'b0, d); check("R6 rx flush empties fifo", d & 32'h3, 32'h0);
        rd(4'hC, 1'b0, d); check("R6 control value stored", d, 32'h02);
        push(8'hD2, a);
        rd(4'h0, 1'b0, d); check("R6 rx after flush", d, 32'hD2);
        tx_ready = 1'b0;
        for (int i = 0; i < 3; i++) wr(4'h4, 1'b0, 32'h55);
        rd(4'h8, 1'b0, d); check("R6 tx holds data before flush", d & 32'h4, 32'h0);
        wr(4'hC, 1'b0, 32'h01);
        rd(4'h8, 1'b0, d); check("R6 tx flush empties fifo", d & 32'h4, 32'h4);
        check("R6 tx_valid low after flush", 32'(tx_valid), 32'd0);
        wr(4'hC, 1'b0, 32'h00);
        clear_pend();
    endtask

    task automatic t_stat_wr();
        logic [31:0] d;
        rd(4'h8, 1'b0, d); check("R7 status before write", d, 32'h04);
        wr(4'h8, 1'b0, 32'hFFFF_FFFF);
        rd(4'h8, 1'b0, d); check("R7 status write ignored", d, 32'h04);
        rd(4'hC, 1'b0, d); check("R7 control untouched by status write", d, 32'h00);
        check("R7 irq untouched", 32'(irq), 32'd0);
    endtask

    task automatic t_irq();
        logic [31:0] d;
        logic a;
        wr(4'hC, 1'b0, 32'h10);
        check("R9 irq low with no pending", 32'(irq), 32'd0);
        push(8'hE0, a);
        check("R8 R9 irq on rx data", 32'(irq), 32'd1);
        rd(4'h0, 1'b0, d);
        check("R8 irq sticky after pop", 32'(irq), 32'd1);
        rd(4'h8, 1'b0, d);
        check("R8 irq cleared by status read", 32'(irq), 32'd0);
        wr(4'hC, 1'b0, 32'h00);
        tx_ready = 1'b1;
        wr(4'h4, 1'b0, 32'h77);
        check("R9 irq masked when disabled", 32'(irq), 32'd0);
        wr(4'hC, 1'b0, 32'h10);
        check("R8 R9 tx write set pending", 32'(irq), 32'd1);
        rd(4'h8, 1'b0, d);
        check("R8 irq cleared after tx pending", 32'(irq), 32'd0);
        wr(4'hC, 1'b0, 32'h00);
        tx_ready = 1'b0;
    endtask

    task automatic t_tx();
        logic [31:0] d;
        tx_ready = 1'b0;
        for (int i = 0; i < 17; i++) wr(4'h4, 1'b0, 32'h100 + 32'(i));
        rd(4'h8, 1'b0, d); check("R2 R10 status tx full", d, 32'h18);
        rd(4'h4, 1'b0, d); check("R10 tx register keeps last write", d, 32'h110);
        @(negedge clk);
        tx_ready = 1'b1;
        for (int i = 0; i < 16; i++) begin
            check("R10 tx_valid while draining", 32'(tx_valid), 32'd1);
            check("R10 tx order", 32'(tx_data), 32'(i));
            @(posedge clk); #1;
        end
        check("R10 full write discarded", 32'(tx_valid), 32'd0);
        tx_ready = 1'b0;
        rd(4'h8, 1'b0, d); check("R10 tx empty after drain", d, 32'h04);
    endtask

    task automatic t_lane();
        logic [31:0] d;
        big_endian = 1'b0;
        wr(4'hD, 1'b1, 32'h0000_1000);
        rd(4'hC, 1'b0, d); check("R11 little byte write lane1", d, 32'h10);
        rd(4'hD, 1'b1, d); check("R11 little byte read lane1", d, 32'h0000_1000);
        wr(4'hC, 1'b0, 32'h00);
        big_endian = 1'b1;
        wr(4'hD, 1'b1, 32'h0020_0000);
        rd(4'hC, 1'b0, d); check("R11 big byte write lane2", d, 32'h20);
        rd(4'hC, 1'b1, d); check("R11 big byte read lane3", d, 32'h2000_0000);
        wr(4'hC, 1'b0, 32'h00);
        big_endian = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_rx_order();
        t_rx_full();
        t_flush();
        t_stat_wr();
        t_irq();
        t_tx();
        t_lane();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule